// File: doc/BRIEF.md
# Upper-Half Lane Controller for a 64-bit PCI Bridge Port

This block runs the upper 32 bits of a 64-bit PCI or PCI-X multiplexed address/data bus on one side of a bridge. A host bus engine reports each cycle's phase: address, second half of a dual address, data, and whether this port is the side that drives the bus. From those flags and the sampled 64-bit strobes, the controller decides whether the upper address/data and command/byte-enable lanes are driven. It produces the upper-half parity one clock behind the lanes and checks the parity it receives. It also drives the 64-bit request strobe when the port is an initiator and the 64-bit acknowledge strobe when the port is a target.

Each tri-state pin is modelled as a value output plus an output enable, and the sampled bus level arrives on a separate input. While reset is held, the request strobe is sampled as a strap that decides whether the port supports 64-bit transfers at all. A port strapped as 32-bit keeps the whole upper half driven to fixed levels for as long as it runs.

Top module: `pci_upper_lane_ctrl`

## Requirements
- R1: The 64-bit capability is taken from `bus_req64_n` on the last clock edge with `rst_n` low. A value of 0 enables 64-bit operation and a value of 1 disables it. The setting holds until the next reset.
- R2: With 64-bit disabled, the block drives `ad_hi_o` to all ones and `cbe_hi_o` to all ones with both enables high in every cycle after reset. From the second cycle after reset it also drives `par64_o`=0 with `par64_oe`=1, because thirty-six ones already have even parity.
- R3: With 64-bit enabled, in a data phase where `cyc_drive`=1 and both `bus_req64_n` and `bus_ack64_n` are 0, `ad_hi_o`/`cbe_hi_o` carry `tx_ad_hi`/`tx_cbe_hi` with the enables high in that same cycle. In every other data phase the enables are low.
- R4: With 64-bit enabled, in an address phase with `cyc_addr`=1, `cyc_dual`=1, `cyc_drive`=1 and `bus_req64_n`=0, the upper lanes carry `tx_ad_hi`/`tx_cbe_hi` (high address and command) in that same cycle. This applies to both halves of a dual address.
- R5: `par64_o` equals the XOR of all bits of `ad_hi_o` and `cbe_hi_o` from the previous cycle, so that the 36 lane bits plus `par64_o` hold an even number of ones. `par64_oe` equals the previous cycle's `ad_hi_oe`, so parity starts and stops one clock after the lanes do.
- R6: With 64-bit enabled, `req64_n_o`=0 and `req64_n_oe`=1 in every cycle where `init_frame` and `init_want64` are both 1. In the first cycle after that stops, the strobe is driven to 1 with the enable high. In the cycle after that, the enable is released.
- R7: With 64-bit enabled, `ack64_n_o`=0 and `ack64_n_oe`=1 in every cycle where `tgt_devsel`=1 and `bus_req64_n`=0. When that stops, the strobe is driven high for exactly one cycle and then released.
- R8: A receive phase is a cycle with 64-bit enabled and `cyc_drive`=0 that is either a data phase with both strobes low on the bus or a dual-address phase with `bus_req64_n` low. After a receive phase, `bus_par64` is sampled one clock later and compared with the even parity of that phase's `bus_ad_hi`/`bus_cbe_hi`. On a mismatch, `par64_err` is high for exactly one cycle, two clocks after the receive phase. A matching parity leaves `par64_err` low.
- R9: With 64-bit disabled, `ack64_n_oe` never rises even when `tgt_devsel` and a low `bus_req64_n` are present. With 64-bit disabled, `par64_err` stays low whatever parity is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low; also the strap window |
| cyc_addr | input | 1 | Current cycle is an address phase |
| cyc_dual | input | 1 | Address phase belongs to a dual address |
| cyc_data | input | 1 | Current cycle is a data phase |
| cyc_drive | input | 1 | This port drives address/data this cycle |
| init_frame | input | 1 | Host asserts the frame strobe as initiator |
| init_want64 | input | 1 | Host requests a 64-bit transfer |
| tgt_devsel | input | 1 | Host asserts device select as target |
| tx_ad_hi | input | 32 | Upper address/data to drive |
| tx_cbe_hi | input | 4 | Upper command/byte enables to drive (active low) |
| bus_ad_hi | input | 32 | Sampled upper address/data lanes |
| bus_cbe_hi | input | 4 | Sampled upper command/byte-enable lanes |
| bus_par64 | input | 1 | Sampled upper parity |
| bus_req64_n | input | 1 | Sampled 64-bit request strobe (active low) |
| bus_ack64_n | input | 1 | Sampled 64-bit acknowledge strobe (active low) |
| ad_hi_o | output | 32 | Upper address/data value |
| ad_hi_oe | output | 1 | Upper address/data enable |
| cbe_hi_o | output | 4 | Upper command/byte-enable value |
| cbe_hi_oe | output | 1 | Upper command/byte-enable enable |
| par64_o | output | 1 | Upper parity value |
| par64_oe | output | 1 | Upper parity enable |
| req64_n_o | output | 1 | Request strobe value |
| req64_n_oe | output | 1 | Request strobe enable |
| ack64_n_o | output | 1 | Acknowledge strobe value |
| ack64_n_oe | output | 1 | Acknowledge strobe enable |
| par64_err | output | 1 | One-cycle pulse on a received upper-parity mismatch |

## Verification
Several properties are checked on every cycle:
- The parity enable lags the lane enable by exactly one clock, and the parity value matches the previous cycle's lanes.
- An asserted acknowledge always coincides with a low request on the bus.
- Each strobe spends exactly one driven-high cycle after it is deasserted.
- A 32-bit strap keeps the lanes driven to ones, never acknowledges and never flags a parity error.
- Driven lanes in 64-bit mode always have a low request strobe on the bus.

Only the bench scenarios can show the following:
- The strap being captured from the reset window in both polarities.
- The exact lane values in data and dual-address phases.
- That a missing acknowledge keeps the lanes undriven.
- That a wrong received parity raises the error flag on the right cycle and for one cycle only, while a correct parity does not.

// File: rtl/ulc_pkg.sv
package ulc_pkg;
   // Index of each handshake strobe inside the strobe array
   typedef enum int {
      STB_REQ = 0,
      STB_ACK = 1
   } ulc_strobe_e;

   localparam int ULC_NUM_STROBES = 2;
endpackage

// File: rtl/ulc_strap.sv
// Captures the 64-bit capability from the request strobe while reset is held
module ulc_strap (
   input  logic clk,
   input  logic rst_n,
   input  logic strap_n,
   output logic cap64
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         cap64 <= ~strap_n;
   end
endmodule

// File: rtl/ulc_strobe.sv
// Active-low sustained strobe: driven low while active, then driven high
// for one cycle, then released.
module ulc_strobe (
   input  logic clk,
   input  logic rst_n,
   input  logic act,
   output logic strobe_n,
   output logic strobe_oe
);
   logic was_act_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         was_act_q <= 1'b0;
      else
         was_act_q <= act;
   end

   assign strobe_n  = ~act;
   assign strobe_oe = act | was_act_q;
endmodule

// File: rtl/ulc_parity.sv
// Upper-half parity: generation one clock behind the lanes, plus a check
// of received parity one clock behind the received phase.
module ulc_parity #(
   parameter int VEC_W = 36
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             drv_oe,
   input  logic [VEC_W-1:0] drv_vec,
   input  logic             rx_phase,
   input  logic [VEC_W-1:0] rx_vec,
   input  logic             rx_par,
   output logic             par_o,
   output logic             par_oe,
   output logic             par_err
);
   logic chk_q;
   logic calc_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         par_o   <= 1'b0;
         par_oe  <= 1'b0;
         chk_q   <= 1'b0;
         calc_q  <= 1'b0;
         par_err <= 1'b0;
      end else begin
         par_o   <= ^drv_vec;
         par_oe  <= drv_oe;
         chk_q   <= rx_phase;
         calc_q  <= ^rx_vec;
         par_err <= chk_q & (rx_par ^ calc_q);
      end
   end
endmodule

// File: rtl/pci_upper_lane_ctrl.sv
module pci_upper_lane_ctrl #(
   parameter int HALF_W = 32,
   parameter int BE_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cyc_addr,
   input  logic              cyc_dual,
   input  logic              cyc_data,
   input  logic              cyc_drive,
   input  logic              init_frame,
   input  logic              init_want64,
   input  logic              tgt_devsel,
   input  logic [HALF_W-1:0] tx_ad_hi,
   input  logic [BE_W-1:0]   tx_cbe_hi,
   input  logic [HALF_W-1:0] bus_ad_hi,
   input  logic [BE_W-1:0]   bus_cbe_hi,
   input  logic              bus_par64,
   input  logic              bus_req64_n,
   input  logic              bus_ack64_n,
   output logic [HALF_W-1:0] ad_hi_o,
   output logic              ad_hi_oe,
   output logic [BE_W-1:0]   cbe_hi_o,
   output logic              cbe_hi_oe,
   output logic              par64_o,
   output logic              par64_oe,
   output logic              req64_n_o,
   output logic              req64_n_oe,
   output logic              ack64_n_o,
   output logic              ack64_n_oe,
   output logic              par64_err
);
   import ulc_pkg::*;

   localparam int VEC_W = HALF_W + BE_W;

   generate
      if (HALF_W != 8 * BE_W) begin : g_bad_width
         $error("HALF_W must be eight times BE_W");
      end
      if (HALF_W < 8) begin : g_too_narrow
         $error("HALF_W must be at least 8");
      end
   endgenerate

   logic cap64;
   logic drv_addr, drv_data, lane_on;
   logic rx_phase;
   logic [ULC_NUM_STROBES-1:0] stb_act, stb_n, stb_oe;

   ulc_strap u_strap (
      .clk     (clk),
      .rst_n   (rst_n),
      .strap_n (bus_req64_n),
      .cap64   (cap64)
   );

   // Lane ownership decode
   assign drv_addr = cyc_drive & cyc_addr & cyc_dual & ~bus_req64_n;
   assign drv_data = cyc_drive & cyc_data & ~bus_req64_n & ~bus_ack64_n;
   assign lane_on  = cap64 ? (drv_addr | drv_data) : 1'b1;

   assign ad_hi_oe  = rst_n & lane_on;
   assign cbe_hi_oe = rst_n & lane_on;
   assign ad_hi_o   = cap64 ? tx_ad_hi  : {HALF_W{1'b1}};
   assign cbe_hi_o  = cap64 ? tx_cbe_hi : {BE_W{1'b1}};

   // Receive-phase qualifier for the parity check
   assign rx_phase = cap64 & ~cyc_drive & ~bus_req64_n &
                     ((cyc_data & ~bus_ack64_n) | (cyc_addr & cyc_dual));

   ulc_parity #(.VEC_W(VEC_W)) u_parity (
      .clk      (clk),
      .rst_n    (rst_n),
      .drv_oe   (ad_hi_oe),
      .drv_vec  ({ad_hi_o, cbe_hi_o}),
      .rx_phase (rx_phase),
      .rx_vec   ({bus_ad_hi, bus_cbe_hi}),
      .rx_par   (bus_par64),
      .par_o    (par64_o),
      .par_oe   (par64_oe),
      .par_err  (par64_err)
   );

   // Handshake strobes
   assign stb_act[STB_REQ] = rst_n & cap64 & init_frame & init_want64;
   assign stb_act[STB_ACK] = rst_n & cap64 & tgt_devsel & ~bus_req64_n;

   generate
      for (genvar gi = 0; gi < ULC_NUM_STROBES; gi++) begin : g_strobe
         ulc_strobe u_strobe (
            .clk       (clk),
            .rst_n     (rst_n),
            .act       (stb_act[gi]),
            .strobe_n  (stb_n[gi]),
            .strobe_oe (stb_oe[gi])
         );
      end
   endgenerate

   assign req64_n_o  = stb_n[STB_REQ];
   assign req64_n_oe = stb_oe[STB_REQ];
   assign ack64_n_o  = stb_n[STB_ACK];
   assign ack64_n_oe = stb_oe[STB_ACK];
endmodule

// File: rtl/ulc_chk.sv
module ulc_chk #(
   parameter int HALF_W = 32,
   parameter int BE_W   = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cap64,
   input logic              cyc_drive,
   input logic              bus_req64_n,
   input logic [HALF_W-1:0] ad_hi_o,
   input logic              ad_hi_oe,
   input logic [BE_W-1:0]   cbe_hi_o,
   input logic              cbe_hi_oe,
   input logic              par64_o,
   input logic              par64_oe,
   input logic              req64_n_o,
   input logic              req64_n_oe,
   input logic              ack64_n_o,
   input logic              ack64_n_oe,
   input logic              par64_err
);
   assert_par_oe_lag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      par64_oe == $past(ad_hi_oe));

   assert_par_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
      par64_oe |-> (par64_o == $past(^{ad_hi_o, cbe_hi_o})));

   assert_lane_needs_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cap64 && ad_hi_oe) |-> (!bus_req64_n && cyc_drive));

   assert_req_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(req64_n_oe && !req64_n_o) && !(req64_n_oe && !req64_n_o))
         |-> (req64_n_oe && req64_n_o));

   assert_req_high_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req64_n_oe && req64_n_o) |=> !(req64_n_oe && req64_n_o));

   assert_ack_needs_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ack64_n_oe && !ack64_n_o) |-> !bus_req64_n);

   assert_ack_high_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ack64_n_oe && ack64_n_o) |=> !(ack64_n_oe && ack64_n_o));

   assert_nocap_driven_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !cap64 |-> (ad_hi_oe && cbe_hi_oe && (&ad_hi_o) && (&cbe_hi_o)));

   assert_nocap_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !cap64 |-> (!(ack64_n_oe && !ack64_n_o) && !par64_err));
endmodule

bind pci_upper_lane_ctrl ulc_chk #(.HALF_W(HALF_W), .BE_W(BE_W)) u_ulc_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cap64       (cap64),
   .cyc_drive   (cyc_drive),
   .bus_req64_n (bus_req64_n),
   .ad_hi_o     (ad_hi_o),
   .ad_hi_oe    (ad_hi_oe),
   .cbe_hi_o    (cbe_hi_o),
   .cbe_hi_oe   (cbe_hi_oe),
   .par64_o     (par64_o),
   .par64_oe    (par64_oe),
   .req64_n_o   (req64_n_o),
   .req64_n_oe  (req64_n_oe),
   .ack64_n_o   (ack64_n_o),
   .ack64_n_oe  (ack64_n_oe),
   .par64_err   (par64_err)
);

// File: tb/test_pci_upper_lane_ctrl.sv
module test_pci_upper_lane_ctrl;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cyc_addr, cyc_dual, cyc_data, cyc_drive;
   logic        init_frame, init_want64, tgt_devsel;
   logic [31:0] tx_ad_hi, bus_ad_hi;
   logic [3:0]  tx_cbe_hi, bus_cbe_hi;
   logic        bus_par64, bus_req64_n, bus_ack64_n;
   logic [31:0] ad_hi_o;
   logic [3:0]  cbe_hi_o;
   logic        ad_hi_oe, cbe_hi_oe, par64_o, par64_oe;
   logic        req64_n_o, req64_n_oe, ack64_n_o, ack64_n_oe, par64_err;

   int n_chk = 0;
   int n_err = 0;

   pci_upper_lane_ctrl i_pci_upper_lane_ctrl (
      .clk(clk), .rst_n(rst_n),
      .cyc_addr(cyc_addr), .cyc_dual(cyc_dual), .cyc_data(cyc_data),
      .cyc_drive(cyc_drive), .init_frame(init_frame), .init_want64(init_want64),
      .tgt_devsel(tgt_devsel), .tx_ad_hi(tx_ad_hi), .tx_cbe_hi(tx_cbe_hi),
      .bus_ad_hi(bus_ad_hi), .bus_cbe_hi(bus_cbe_hi), .bus_par64(bus_par64),
      .bus_req64_n(bus_req64_n), .bus_ack64_n(bus_ack64_n),
      .ad_hi_o(ad_hi_o), .ad_hi_oe(ad_hi_oe), .cbe_hi_o(cbe_hi_o),
      .cbe_hi_oe(cbe_hi_oe), .par64_o(par64_o), .par64_oe(par64_oe),
      .req64_n_o(req64_n_o), .req64_n_oe(req64_n_oe),
      .ack64_n_o(ack64_n_o), .ack64_n_oe(ack64_n_oe), .par64_err(par64_err)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic idle();
      cyc_addr = 0; cyc_dual = 0; cyc_data = 0; cyc_drive = 0;
      init_frame = 0; init_want64 = 0; tgt_devsel = 0;
      tx_ad_hi = '0; tx_cbe_hi = '0; bus_ad_hi = '0; bus_cbe_hi = '0;
      bus_par64 = 0; bus_req64_n = 1; bus_ack64_n = 1;
   endtask

   // Step to the next falling edge; inputs change there
   task automatic step();
      @(negedge clk);
   endtask

   task automatic do_reset(input logic strap_n);
      step();
      idle();
      rst_n = 0;
      bus_req64_n = strap_n;
      repeat (3) step();
      #1;
      check("R1 reset ad_oe", {63'd0, ad_hi_oe}, 64'd0);
      check("R1 reset par_oe/err", {62'd0, par64_oe, par64_err}, 64'd0);
      check("R1 reset strobes oe", {62'd0, req64_n_oe, ack64_n_oe}, 64'd0);
      rst_n = 1;
      bus_req64_n = 1;
      #1;
   endtask

   task automatic t_data_drive();
      step(); idle();
      cyc_data = 1; cyc_drive = 1; bus_req64_n = 0; bus_ack64_n = 0;
      tx_ad_hi = 32'hA5C3_1E77; tx_cbe_hi = 4'h6;
      #1;
      check("R3 data lanes oe", {62'd0, ad_hi_oe, cbe_hi_oe}, 64'd3);
      check("R3 data value", {28'd0, ad_hi_o, cbe_hi_o}, {28'd0, 32'hA5C3_1E77, 4'h6});
      step(); idle();
      #1;
      check("R3 lanes released", {63'd0, ad_hi_oe}, 64'd0);
      check("R5 par oe lag", {63'd0, par64_oe}, 64'd1);
      check("R5 par value", {63'd0, par64_o}, {63'd0, ^{32'hA5C3_1E77, 4'h6}});
      step();
      #1;
      check("R5 par released", {63'd0, par64_oe}, 64'd0);
   endtask

   task automatic t_data_noack();
      step(); idle();
      cyc_data = 1; cyc_drive = 1; bus_req64_n = 0; bus_ack64_n = 1;
      tx_ad_hi = 32'h1234_5678;
      #1;
      check("R3 no ack lanes off", {63'd0, ad_hi_oe}, 64'd0);
      bus_req64_n = 1; bus_ack64_n = 0;
      #1;
      check("R3 no req lanes off", {63'd0, ad_hi_oe}, 64'd0);
      step(); idle();
      #1;
      check("R5 no par after off", {63'd0, par64_oe}, 64'd0);
   endtask

   task automatic t_dual_addr();
      step(); idle();
      cyc_addr = 1; cyc_dual = 1; cyc_drive = 1; bus_req64_n = 0;
      tx_ad_hi = 32'h0000_00F1; tx_cbe_hi = 4'hD;
      #1;
      check("R4 dual addr 1 oe", {63'd0, ad_hi_oe}, 64'd1);
      check("R4 dual addr 1 val", {28'd0, ad_hi_o, cbe_hi_o}, {28'd0, 32'h0000_00F1, 4'hD});
      step();
      tx_ad_hi = 32'h8000_0003; tx_cbe_hi = 4'h7;
      #1;
      check("R4 dual addr 2 val", {28'd0, ad_hi_o, cbe_hi_o}, {28'd0, 32'h8000_0003, 4'h7});
      check("R5 par after addr 1", {62'd0, par64_oe, par64_o}, {62'd0, 1'b1, ^{32'h0000_00F1, 4'hD}});
      step(); idle();
      #1;
      check("R5 par after addr 2", {62'd0, par64_oe, par64_o}, {62'd0, 1'b1, ^{32'h8000_0003, 4'h7}});
      step(); idle();
      cyc_addr = 1; cyc_drive = 1; bus_req64_n = 0;
      #1;
      check("R4 single addr lanes off", {63'd0, ad_hi_oe}, 64'd0);
   endtask

   task automatic t_req_strobe();
      step(); idle();
      init_frame = 1; init_want64 = 1;
      #1;
      check("R6 req asserted", {62'd0, req64_n_oe, req64_n_o}, {62'd0, 2'b10});
      step();
      #1;
      check("R6 req held", {62'd0, req64_n_oe, req64_n_o}, {62'd0, 2'b10});
      step(); idle();
      #1;
      check("R6 req driven high", {62'd0, req64_n_oe, req64_n_o}, {62'd0, 2'b11});
      step();
      #1;
      check("R6 req released", {63'd0, req64_n_oe}, 64'd0);
      init_frame = 1; init_want64 = 0;
      #1;
      check("R6 frame without want64", {63'd0, req64_n_oe}, 64'd0);
   endtask

   task automatic t_ack_strobe();
      step(); idle();
      tgt_devsel = 1; bus_req64_n = 1;
      #1;
      check("R7 no ack without req", {63'd0, ack64_n_oe}, 64'd0);
      bus_req64_n = 0;
      #1;
      check("R7 ack asserted", {62'd0, ack64_n_oe, ack64_n_o}, {62'd0, 2'b10});
      step(); idle();
      #1;
      check("R7 ack driven high", {62'd0, ack64_n_oe, ack64_n_o}, {62'd0, 2'b11});
      step();
      #1;
      check("R7 ack released", {63'd0, ack64_n_oe}, 64'd0);
   endtask

   task automatic t_parity_rx(input logic corrupt, input logic dual);
      logic expect_err;
      logic good;
      expect_err = corrupt;
      good = ^{32'hDEAD_0F0F, 4'hB};
      step(); idle();
      if (dual) begin
         cyc_addr = 1; cyc_dual = 1;
      end else begin
         cyc_data = 1; bus_ack64_n = 0;
      end
      bus_req64_n = 0;
      bus_ad_hi = 32'hDEAD_0F0F; bus_cbe_hi = 4'hB;
      step(); idle();
      bus_par64 = good ^ corrupt;
      #1;
      check("R8 no early err", {63'd0, par64_err}, 64'd0);
      step(); idle();
      #1;
      check("R8 err pulse", {63'd0, par64_err}, {63'd0, expect_err});
      step();
      #1;
      check("R8 err one cycle", {63'd0, par64_err}, 64'd0);
   endtask

   task automatic t_disabled();
      step(); step();
      #1;
      check("R2 lanes driven", {62'd0, ad_hi_oe, cbe_hi_oe}, 64'd3);
      check("R2 lanes all ones", {28'd0, ad_hi_o, cbe_hi_o}, {28'd0, 32'hFFFF_FFFF, 4'hF});
      check("R2 parity driven zero", {62'd0, par64_oe, par64_o}, {62'd0, 2'b10});
      step(); idle();
      cyc_data = 1; cyc_drive = 1; bus_req64_n = 0; bus_ack64_n = 0;
      tx_ad_hi = 32'h0;
      #1;
      check("R2 tx ignored", {32'd0, ad_hi_o}, {32'd0, 32'hFFFF_FFFF});
      step(); idle();
      tgt_devsel = 1; bus_req64_n = 0;
      init_frame = 1; init_want64 = 1;
      #1;
      check("R9 no ack when disabled", {63'd0, ack64_n_oe}, 64'd0);
      check("R1 no req when disabled", {63'd0, req64_n_oe}, 64'd0);
      step(); idle();
      cyc_data = 1; bus_req64_n = 0; bus_ack64_n = 0;
      bus_ad_hi = 32'h1; bus_cbe_hi = 4'h0;
      step(); idle();
      bus_par64 = 1'b0;
      step(); idle();
      #1;
      check("R9 parity ignored", {63'd0, par64_err}, 64'd0);
      step();
      #1;
      check("R9 parity ignored late", {63'd0, par64_err}, 64'd0);
      check("R2 still driven", {62'd0, ad_hi_oe, par64_oe}, 64'd3);
   endtask

   initial begin
      rst_n = 0;
      idle();
      do_reset(1'b0);
      t_data_drive();
      t_data_noack();
      t_dual_addr();
      t_req_strobe();
      t_ack_strobe();
      t_parity_rx(1'b1, 1'b0);
      t_parity_rx(1'b0, 1'b0);
      t_parity_rx(1'b1, 1'b1);
      do_reset(1'b1);
      t_disabled();
      do_reset(1'b0);
      t_data_drive();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule